// File: doc/BRIEF.md
# Write Status Polling Read Path

This block sits on the read side of a flash array controller. While the embedded program or erase engine runs, it replaces the array data that a host would read with a status byte. That byte carries two independent completion indicators. The top bit is a polarity flag whose meaning depends on the operation: for a program it is the inverse of the top bit of the byte being written, and for an erase it is held at zero. The next bit down is a toggle flag that flips once for every host read. All lower bits read as zero. When the engine drops its busy flag, reads return true array data again, so a host can tell that the operation is over by polling either flag.

The block watches a level busy flag from the engine. The cycle in which that flag is first seen high is taken as the end of the final command cycle. On that edge the block latches the operation kind and the programmed byte, clears the toggle flag, and moves from `IDLE` into `PGM_POLL` or `ERS_POLL`. The transitions are `IDLE -> PGM_POLL` (busy seen with program kind), `IDLE -> ERS_POLL` (busy seen with erase kind), and `PGM_POLL -> IDLE` / `ERS_POLL -> IDLE` (busy seen low). Each rising edge of the read strobe captures one result into a registered output and pulses a valid flag on the next cycle.

Top module: `write_status_poll`

## Requirements
- R1: After reset, `rd_data` is all zeros, and `rd_valid` and `status_mode` are 0.
- R2: A read outside a poll state, or in a cycle where `busy` is low, returns `array_data` as sampled at the strobe's rising edge. The result appears on `rd_data` together with a one-cycle `rd_valid` pulse in the cycle after the edge.
- R3: In `PGM_POLL`, bit 7 of every read is the inverse of bit 7 of `op_byte` as latched at entry. Later changes on `op_byte` have no effect.
- R4: In `ERS_POLL`, bit 7 of every read is 0.
- R5: Bit 6 of the first status read after entry is 0, and it alternates on each later status read of the same operation.
- R6: The toggle advances and `rd_valid` pulses only once per rising edge of `rd_strobe`, however long the strobe is held high.
- R7: Bits 5 to 0 of every status read are 0.
- R8: Once `busy` falls, the state returns to `IDLE` and reads return array data. A new operation clears the toggle again.
- R9: Status is reported from the cycle after `busy` is first seen high. A read captured on that same edge returns array data and does not advance the toggle. `status_mode` is 1 exactly while in a poll state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Embedded operation in progress |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| op_byte | input | 8 | Byte being programmed |
| rd_strobe | input | 1 | Host read strobe (level) |
| array_data | input | 8 | True data from the array |
| rd_data | output | 8 | Captured read result |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| status_mode | output | 1 | High while status replaces array data |

## Verification
The hardest case to reach from the ports is a read strobe that rises on the same edge where busy is first seen. That read must return array data and must leave the toggle untouched, so the next read still shows 0 on bit 6. The stimulus reaches it by driving busy and the strobe in the same half cycle. A strobe held high for several cycles is also driven directly, because random stimulus seldom produces it. Random operations with random kinds, bytes, read counts and array words cover the rest.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PGM_POLL = 2'd1,
        ST_ERS_POLL = 2'd2
    } wsp_state_t;
endpackage

// File: rtl/wsp_edge.sv
module wsp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;

    // R6: a rise cannot repeat on the next cycle
    p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/wsp_toggle.sv
module wsp_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    output logic tog_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     tog_o <= 1'b0;
        else if (clr_i) tog_o <= 1'b0;
        else if (adv_i) tog_o <= ~tog_o;
    end
endmodule

// File: rtl/wsp_fsm.sv
module wsp_fsm
    import wsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy_i,
    input  logic       erase_i,
    output wsp_state_t state_o,
    output logic       enter_o
);
    wsp_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (busy_i) st_d = erase_i ? ST_ERS_POLL : ST_PGM_POLL;
            ST_PGM_POLL: if (!busy_i) st_d = ST_IDLE;
            ST_ERS_POLL: if (!busy_i) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    assign state_o = st_q;
    assign enter_o = (st_q == ST_IDLE) && busy_i;

    // R8: leaving a poll state always lands in IDLE when busy is low
    p_exit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !busy_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/write_status_poll.sv
module write_status_poll
    import wsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              op_erase,
    input  logic [DATA_W-1:0] op_byte,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              status_mode
);
    localparam int POL_BIT = DATA_W - 1;
    localparam int TOG_BIT = DATA_W - 2;

    wsp_state_t        state;
    logic              enter;
    logic              rd_rise;
    logic              tog;
    logic              in_status;
    logic              status_q;
    logic              pol_src_q;
    logic [DATA_W-1:0] status_word;

    wsp_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (busy),
        .erase_i (op_erase),
        .state_o (state),
        .enter_o (enter)
    );

    wsp_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (rd_strobe),
        .rise_o  (rd_rise)
    );

    assign in_status = (state != ST_IDLE) && busy;

    wsp_toggle u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (enter),
        .adv_i (rd_rise && in_status),
        .tog_o (tog)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     pol_src_q <= 1'b0;
        else if (enter) pol_src_q <= op_byte[POL_BIT];
    end

    always_comb begin
        status_word = '0;
        unique case (state)
            ST_PGM_POLL: status_word[POL_BIT] = ~pol_src_q;
            ST_ERS_POLL: status_word[POL_BIT] = 1'b0;
            default:     status_word[POL_BIT] = 1'b0;
        endcase
        status_word[TOG_BIT] = tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            status_q <= 1'b0;
        end else begin
            rd_valid <= rd_rise;
            if (rd_rise) begin
                rd_data  <= in_status ? status_word : array_data;
                status_q <= in_status;
            end
        end
    end

    assign status_mode = (state != ST_IDLE);

    // R2: a data read echoes the array word seen at the strobe edge
    p_data_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !status_q) |-> rd_data == $past(array_data));

    // R4: erase status never shows a set polarity bit
    p_erase_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(state == ST_ERS_POLL && busy)) |-> !rd_data[POL_BIT]);

    // R7: low bits are zero in every status read
    p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && status_q) |-> rd_data[TOG_BIT-1:0] == '0);

    // R5: first status read after entry shows toggle 0
    p_tog_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> !tog);

    // R9: status_mode only rises after busy was seen
    p_mode_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_mode) |-> $past(busy));
endmodule

// File: tb/tb_write_status_poll.sv
module tb_write_status_poll;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic       op_erase = 1'b0;
    logic [7:0] op_byte = '0;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       status_mode;

    int tests = 0;
    int fails = 0;
    logic m_tog;
    logic m_erase;
    logic [7:0] m_byte;

    always #2 clk = ~clk;

    write_status_poll dut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
        .op_byte(op_byte), .rd_strobe(rd_strobe), .array_data(array_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .status_mode(status_mode)
    );

    function automatic logic [7:0] exp_status(logic er, logic [7:0] b, logic t);
        logic [7:0] v;
        v = '0;
        v[7] = er ? 1'b0 : ~b[7];
        v[6] = t;
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one read: strobe rises before an edge, result sampled after it
    task automatic do_read(input logic [7:0] arr, output logic [7:0] got, output logic vld);
        @(negedge clk);
        array_data = arr;
        rd_strobe = 1'b1;
        @(posedge clk); #1;
        got = rd_data; vld = rd_valid;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic start_op(logic er, logic [7:0] b);
        @(negedge clk);
        busy = 1'b1; op_erase = er; op_byte = b;
        m_erase = er; m_byte = b; m_tog = 1'b0;
        @(posedge clk); #1;
        check("R9 status_mode", status_mode, 1);
    endtask

    task automatic end_op();
        @(negedge clk);
        busy = 1'b0;
        @(posedge clk); #1;
        check("R8 status_mode low", status_mode, 0);
    endtask

    task automatic status_read(string req);
        logic [7:0] g; logic v;
        do_read(8'($urandom), g, v);
        check({req, " valid"}, v, 1);
        check(req, g, exp_status(m_erase, m_byte, m_tog));
        m_tog = ~m_tog;
    endtask

    initial begin
        #40000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] g; logic v; logic [7:0] a;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 rd_data", rd_data, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 status_mode", status_mode, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 idle read, with valid pulse lasting one cycle
        do_read(8'h5A, g, v);
        check("R2 idle data", g, 8'h5A);
        check("R2 valid", v, 1);
        @(posedge clk); #1;
        check("R2 valid single", rd_valid, 0);

        // R3 program, later op_byte change ignored
        start_op(1'b0, 8'h80);
        op_byte = 8'h00;
        status_read("R3 program status");
        status_read("R5 toggle second");
        status_read("R7 program third");
        end_op();
        do_read(8'h80, g, v);
        check("R8 data after program", g, 8'h80);

        // R4 erase
        start_op(1'b1, 8'h00);
        status_read("R4 erase status");
        status_read("R4 erase second");
        end_op();
        do_read(8'hFF, g, v);
        check("R8 erased data", g, 8'hFF);

        // R6 held strobe: one capture, one toggle advance
        start_op(1'b0, 8'h11);
        @(negedge clk); rd_strobe = 1'b1;
        @(posedge clk); #1;
        check("R6 first valid", rd_valid, 1);
        check("R6 first data", rd_data, exp_status(1'b0, 8'h11, 1'b0));
        m_tog = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check("R6 held no valid", rd_valid, 0);
        end
        @(negedge clk); rd_strobe = 1'b0;
        status_read("R6 after hold toggle");
        end_op();

        // R9 read on the same edge busy is first seen
        @(negedge clk);
        busy = 1'b1; op_erase = 1'b0; op_byte = 8'h7F;
        array_data = 8'h3C; rd_strobe = 1'b1;
        @(posedge clk); #1;
        check("R9 same-edge data", rd_data, 8'h3C);
        @(negedge clk); rd_strobe = 1'b0;
        m_erase = 1'b0; m_byte = 8'h7F; m_tog = 1'b0;
        status_read("R9 toggle untouched");
        end_op();

        // random operations
        for (int n = 0; n < 40; n++) begin
            start_op(1'($urandom), 8'($urandom));
            for (int k = 0; k < 1 + ($urandom % 5); k++) begin
                status_read("R5 random status");
                repeat ($urandom % 3) @(negedge clk);
            end
            end_op();
            a = 8'($urandom);
            do_read(a, g, v);
            check("R8 random data", g, a);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule